// File: doc/BRIEF.md
# Three-Tone Plus Noise Sound Generator

This block produces a mixed audio sample from three square-wave tone voices and one pseudo-random noise voice. Software programs it through one write-only byte port. A byte either selects a target register and loads its low nibble, or it loads further bits into the target chosen by the last selecting byte. A 10-bit tone period can therefore be set with two writes. All timing advances on a clock-enable pulse, `tick`, which the surrounding logic asserts once every 16 input clocks.

Each voice has a 4-bit attenuation. The output `mix_out` is the unsigned sum of the linear amplitudes of the voices whose level is high. The 1-bit level of each voice is also brought out on `ch_level` for checking.

The noise voice is a 16-bit shift register. It shifts at one of three fixed rates or follows tone voice 2. It runs in white mode or periodic mode, and it restarts from a fixed seed whenever its control register is written.

Top module: `sqnoise_gen`

## Requirements
- R1: A write with bit 7 = 1 is a select byte. Bits 6:5 name the voice (0–3), and bit 4 picks attenuation (1) or tone/noise control (0). Bits 3:0 are stored in the low 4 bits of that register, and the selection is remembered.
- R2: A write with bit 7 = 0 is a continuation byte for the remembered register and leaves the selection unchanged. Bits 5:0 become period bits 9:4 of a selected tone. Bits 3:0 become a selected attenuation. Bits 2:0 become the noise control.
- R3: A tone voice with nonzero period P inverts its level on the first `tick` with its counter at zero, and then every P ticks. Its level never changes in a cycle without `tick`.
- R4: A tone voice whose period is 0 holds its level at 1.
- R5: The noise control uses bits 1:0 as the rate. Codes 0, 1 and 2 give a noise clock that toggles every 16, 32 and 64 ticks, with a shift on each of its rising transitions. Code 3 shifts on each rising transition of tone voice 2's level.
- R6: On a shift, the 16-bit register moves right and the feedback enters bit 15. The feedback is bit 0 XOR bit 3 when control bit 2 = 1 (white), and bit 0 alone when it is 0 (periodic). The noise level is bit 0, and the register is never all-zero.
- R7: Every write to the noise control sets the shift register to 0x8000. This write wins over a shift due in the same cycle.
- R8: Attenuation codes 0 to 15 map to amplitudes 32767, 26028, 20675, 16422, 13045, 10362, 8231, 6568, 5193, 4125, 3277, 2603, 2067, 1642, 1304 and 0. `mix_out` is the sum of the amplitudes of the voices whose level is 1.
- R9: After reset, every attenuation is 15, every period is 0 and the noise control is 0. The shift register holds 0x8000 and the selection points at voice 0 tone. As a result, `ch_level` = 4'b0111 and `mix_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte written to the port |
| tick | input | 1 | Clock enable, one pulse per 16 clocks |
| mix_out | output | 17 | Unsigned sum of active voice amplitudes |
| ch_level | output | 4 | Levels of tone 0..2 (bits 2:0) and noise (bit 3) |

## Verification
The bench has to prove that a write to the noise control and a shift due in the same cycle are resolved with the seed winning. To provoke this, the noise voice is set to follow tone voice 2 with a period of 1, so that a shift is due on every second tick. The control is then rewritten, together with `tick`, on a cycle where the bench model predicts a rising edge of tone 2. A lost seed leaves the register one shift ahead. The check judges this from the tick on which the noise level next rises, compared with the model over the following ticks. A second overlap, a period rewrite landing on a counter expiry, is covered by random writes mixed with random ticks.

// File: rtl/sqnoise_gen.sv
module sqnoise_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        tick,
  output logic [16:0] mix_out,
  output logic [3:0]  ch_level
);
  localparam int PW = 10;
  localparam int LW = 16;
  localparam logic [LW-1:0] SEED = 16'h8000;

  logic [PW-1:0] per [3];
  logic [PW-1:0] cnt [3];
  logic [2:0]    tog;
  logic [3:0]    att [4];
  logic [2:0]    nctl;
  logic [7:0]    ncnt;
  logic          ntog;
  logic [LW-1:0] lfsr;
  logic [1:0]    lch;
  logic          lvol;

  function automatic logic [14:0] amp(input logic [3:0] a);
    case (a)
      4'd0:  amp = 15'd32767;  4'd1:  amp = 15'd26028;
      4'd2:  amp = 15'd20675;  4'd3:  amp = 15'd16422;
      4'd4:  amp = 15'd13045;  4'd5:  amp = 15'd10362;
      4'd6:  amp = 15'd8231;   4'd7:  amp = 15'd6568;
      4'd8:  amp = 15'd5193;   4'd9:  amp = 15'd4125;
      4'd10: amp = 15'd3277;   4'd11: amp = 15'd2603;
      4'd12: amp = 15'd2067;   4'd13: amp = 15'd1642;
      4'd14: amp = 15'd1304;   default: amp = 15'd0;
    endcase
  endfunction

  wire       is_sel   = wr_data[7];
  wire [1:0] wch      = is_sel ? wr_data[6:5] : lch;
  wire       wvol     = is_sel ? wr_data[4] : lvol;
  wire       wr_noise = wr_en && !wvol && (wch == 2'd3);

  logic [2:0] expire;
  always_comb
    for (int k = 0; k < 3; k++)
      expire[k] = tick && (per[k] != '0) && (cnt[k] == '0);

  wire [7:0] nlen   = 8'd16 << nctl[1:0];
  wire       nexp   = tick && (ncnt == 8'd0);
  wire       nshift = (nctl[1:0] == 2'd3) ? (expire[2] && !tog[2]) : (nexp && !ntog);
  wire       fb     = nctl[2] ? (lfsr[0] ^ lfsr[3]) : lfsr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        per[k] <= '0;
        cnt[k] <= '0;
      end
      for (int k = 0; k < 4; k++) att[k] <= 4'hF;
      tog  <= '0;
      nctl <= '0;
      ncnt <= '0;
      ntog <= 1'b0;
      lfsr <= SEED;
      lch  <= 2'd0;
      lvol <= 1'b0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (expire[k]) begin
          cnt[k] <= per[k] - 1'b1;
          tog[k] <= ~tog[k];
        end else if (tick && cnt[k] != '0) begin
          cnt[k] <= cnt[k] - 1'b1;
        end
      end
      if (nexp) begin
        ncnt <= nlen - 8'd1;
        ntog <= ~ntog;
      end else if (tick) begin
        ncnt <= ncnt - 8'd1;
      end
      if (nshift) lfsr <= {fb, lfsr[LW-1:1]};
      if (wr_en) begin
        if (is_sel) begin
          lch  <= wr_data[6:5];
          lvol <= wr_data[4];
        end
        if (wvol) att[wch] <= wr_data[3:0];
        else if (wch == 2'd3) begin
          nctl <= wr_data[2:0];
          lfsr <= SEED;
        end else begin
          for (int k = 0; k < 3; k++)
            if (wch == 2'(k)) begin
              if (is_sel) per[k][3:0]    <= wr_data[3:0];
              else        per[k][PW-1:4] <= wr_data[5:0];
            end
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < 3; k++) ch_level[k] = (per[k] == '0) ? 1'b1 : tog[k];
    ch_level[3] = lfsr[0];
    mix_out = '0;
    for (int k = 0; k < 4; k++)
      if (ch_level[k]) mix_out = mix_out + 17'(amp(att[k]));
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n) lfsr != '0); // R6
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !wr_en) |=> $stable(lfsr)); // R6
  AST_NOISE_SEED: assert property (@(posedge clk) disable iff (!rst_n) wr_noise |=> lfsr == SEED); // R7
  AST_TONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(tog)); // R3
  AST_CONT_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_data[7]) |=> ($stable(lch) && $stable(lvol))); // R2
  AST_QUIET_MIX: assert property (@(posedge clk) disable iff (!rst_n) (att[0] == 4'hF && att[1] == 4'hF && att[2] == 4'hF && att[3] == 4'hF) |-> mix_out == '0); // R8
endmodule

// File: tb/sqnoise_gen_tb.sv
module sqnoise_gen_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [7:0] wr_data = 0;
  logic [16:0] mix_out;
  logic [3:0] ch_level;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sqnoise_gen u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                     .tick(tick), .mix_out(mix_out), .ch_level(ch_level));

  logic [9:0]  m_per [3];
  logic [9:0]  m_cnt [3];
  logic [2:0]  m_tog;
  logic [3:0]  m_att [4];
  logic [2:0]  m_nctl;
  logic [7:0]  m_ncnt;
  logic        m_ntog;
  logic [15:0] m_lfsr;
  logic [1:0]  m_lch;
  logic        m_lvol;

  function automatic int level_amp(input logic [3:0] a);
    int t [16] = '{32767, 26028, 20675, 16422, 13045, 10362, 8231, 6568,
                   5193, 4125, 3277, 2603, 2067, 1642, 1304, 0};
    return t[a];
  endfunction

  function automatic logic [3:0] exp_lvl();
    logic [3:0] l;
    for (int k = 0; k < 3; k++) l[k] = (m_per[k] == 0) ? 1'b1 : m_tog[k];
    l[3] = m_lfsr[0];
    return l;
  endfunction

  function automatic int exp_mix();
    int s = 0;
    logic [3:0] l = exp_lvl();
    for (int k = 0; k < 4; k++) if (l[k]) s += level_amp(m_att[k]);
    return s;
  endfunction

  task automatic mreset();
    for (int k = 0; k < 3; k++) begin m_per[k] = 0; m_cnt[k] = 0; end
    for (int k = 0; k < 4; k++) m_att[k] = 4'hF;
    m_tog = 0; m_nctl = 0; m_ncnt = 0; m_ntog = 0;
    m_lfsr = 16'h8000; m_lch = 0; m_lvol = 0;
  endtask

  task automatic mstep(input bit w, input logic [7:0] d, input bit t);
    logic [2:0] ex;
    bit nx, sh, fbit, sel, vol;
    logic [1:0] ch;
    for (int k = 0; k < 3; k++) ex[k] = t && m_per[k] != 0 && m_cnt[k] == 0;
    nx = t && m_ncnt == 0;
    sh = (m_nctl[1:0] == 3) ? (ex[2] && !m_tog[2]) : (nx && !m_ntog);
    fbit = m_nctl[2] ? (m_lfsr[0] ^ m_lfsr[3]) : m_lfsr[0];
    for (int k = 0; k < 3; k++)
      if (ex[k]) begin m_cnt[k] = m_per[k] - 1; m_tog[k] = ~m_tog[k]; end
      else if (t && m_cnt[k] != 0) m_cnt[k] = m_cnt[k] - 1;
    if (nx) begin m_ncnt = 8'((16 << m_nctl[1:0]) - 1); m_ntog = ~m_ntog; end
    else if (t) m_ncnt = m_ncnt - 1;
    if (sh) m_lfsr = {fbit, m_lfsr[15:1]};
    if (w) begin
      sel = d[7];
      ch  = sel ? d[6:5] : m_lch;
      vol = sel ? d[4] : m_lvol;
      if (sel) begin m_lch = d[6:5]; m_lvol = d[4]; end
      if (vol) m_att[ch] = d[3:0];
      else if (ch == 3) begin m_nctl = d[2:0]; m_lfsr = 16'h8000; end
      else if (sel) m_per[ch][3:0] = d[3:0];
      else m_per[ch][9:4] = d[5:0];
    end
  endtask

  task automatic cmp_model(input string tag);
    checks++;
    if (ch_level !== exp_lvl() || mix_out !== 17'(exp_mix())) begin
      failures++;
      $display("FAIL %s: level=%b mix=%0d expected level=%b mix=%0d",
               tag, ch_level, mix_out, exp_lvl(), exp_mix());
    end
  endtask

  task automatic cmp_val(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en = w; wr_data = d; tick = t;
    @(posedge clk);
    mstep(w, d, t);
    #1; wr_en = 0; tick = 0;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    cmp_val("R9 reset levels", ch_level, 4'b0111);
    cmp_val("R9 reset mix", mix_out, 0);

    step(1, 8'h90, 0);
    cmp_val("R1 select byte attenuation 0 on voice 0", mix_out, 32767);
    step(1, 8'h05, 0);
    cmp_val("R2 continuation byte to attenuation", mix_out, 10362);
    step(1, 8'hB0, 0);
    cmp_val("R4 zero period voice 1 held high", mix_out, 10362 + 32767);

    step(1, 8'hA3, 0);
    step(1, 8'h00, 0);
    cmp_model("R2 period 3 on voice 1");
    step(0, 0, 1);
    cmp_val("R3 first tick toggle", ch_level[1], 1);
    step(0, 0, 1); step(0, 0, 1);
    cmp_val("R3 still high before period", ch_level[1], 1);
    step(0, 0, 1);
    cmp_val("R3 toggle after 3 ticks", ch_level[1], 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    cmp_val("R3 no change without tick", ch_level[1], 0);
    step(0, 0, 1); step(0, 0, 1); step(0, 0, 1);
    cmp_val("R3 second toggle", ch_level[1], 1);

    step(1, 8'hF0, 0);
    step(1, 8'hE4, 0);
    cmp_val("R7 noise level after seed", ch_level[3], 0);
    cmp_model("R8 mix with noise on");
    for (int i = 0; i < 600; i++) begin
      step(0, 0, 1);
      cmp_model("R5 R6 white rate 0");
    end
    step(1, 8'hE1, 0);
    for (int i = 0; i < 700; i++) begin
      step(0, 0, 1);
      cmp_model("R5 R6 periodic rate 1");
    end

    step(1, 8'hC1, 0);
    step(1, 8'h00, 0);
    step(1, 8'hE7, 0);
    seen = 0;
    for (int i = 0; i < 6 && seen == 0; i++) begin
      if (m_tog[2] == 0 && m_cnt[2] == 0) begin
        step(1, 8'hE7, 1);
        seen = 1;
      end else step(0, 0, 1);
    end
    cmp_val("R7 collision provoked", seen, 1);
    cmp_val("R7 seed wins over shift", ch_level[3], 0);
    for (int i = 0; i < 80; i++) begin
      step(0, 0, 1);
      cmp_model("R7 R5 follow voice 2 after seed");
    end

    for (int i = 0; i < 4000; i++) begin
      bit w = ($urandom % 8) == 0;
      logic [7:0] d = 8'($urandom);
      bit t = ($urandom % 2) == 0;
      if (w && !d[7]) d[5:3] = d[5:3] & 3'b000;
      step(w, d, t);
      cmp_model("R1 R2 R3 R6 R8 random");
    end

    @(negedge clk); rst_n = 0;
    @(posedge clk); mreset();
    #2;
    rst_n = 1;
    #1;
    cmp_val("R9 levels after second reset", ch_level, 4'b0111);
    cmp_val("R9 mix after second reset", mix_out, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule